// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel is a pair of bytes, a low byte and a high byte, that are stepped by a qualified increment event. A two-bit mode field per channel selects one of four arrangements:

- a 13-bit count;
- a 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a special setting. For channel 0 this splits the channel into two independent 8-bit counters. For channel 1 it halts the channel.

Every count and control field is loaded through one byte-wide write port. Each channel takes a timer tick from an external clock selector. It can instead count falling edges on an already synchronized count pin. Counting can be made to depend on a gate pin.

Each channel raises a sticky overflow flag. Software can write the flag, and an interrupt-vector acknowledge clears it. Channel 1 also drives a one-cycle overflow pulse, which a serial baud generator or a conversion trigger can use.

When channel 0 is split, its high byte takes over channel 1's run bit and overflow flag. Channel 1 still counts timer ticks and still drives its pulse. In that state it is started and stopped only by its own mode field.

Top module: `dual_tmr`

## Requirements
- R1: After reset, both counts, both flags, all run bits, all mode fields and the overflow pulse are 0.
- R2: In mode 01 the channel counts as 16 bits, {high, low}. The step from 0xFFFF to 0x0000 sets that channel's flag. For channel 1 it also makes `ch1_ovf_pulse` high for the cycle after that step.
- R3: In mode 00 the count is {high[7:0], low[4:0]}, and low bits 7:5 keep their value. The step from 0x1FFF to 0 sets the flag.
- R4: In mode 10 the low byte counts. When it steps past 0xFF it is loaded from the high byte, and the flag is set in that same clock.
- R5: A channel counts only while its run bit is 1 and, when its gate-enable bit is 1, its `gate_pin` is 1. With gate-enable at 0 the gate pin has no effect.
- R6: With the source-select bit at 1, a channel counts falling edges of `ext_pin` (1 sampled, then 0) and ignores `tick`. With the bit at 0 it counts clocks in which `tick` is 1.
- R7: With channel 0 in mode 11, its low byte is an 8-bit counter controlled by run0, gate0 and source0. Stepping past 0xFF sets flag 0 and leaves the high byte alone.
- R8: With channel 0 in mode 11, its high byte counts `tick[0]` while run1 is 1, ignoring gate and source select. Stepping past 0xFF sets flag 1.
- R9: While channel 0 is in mode 11, channel 1 counts `tick[1]` in its modes 00/01/10 regardless of its run bit, and it holds in mode 11. Its overflow pulses `ch1_ovf_pulse` but never sets flag 1.
- R10: With channel 0 not in mode 11, channel 1 in mode 11 holds its count and sets no flag.
- R11: The flags behave as follows. A write to the control register loads flag0 from bit 2 and flag1 from bit 3. `ack[n]` clears flag n. A hardware set in the same clock wins over a software clear.
- R12: The register map is as follows. Address 0 is control: bit0 run0, bit1 run1, bit2 flag0, bit3 flag1. Address 1 is mode: bits 1:0 mode0, bit2 source0, bit3 gate0, bits 5:4 mode1, bit6 source1, bit7 gate1. Addresses 2/3 are channel 0 low/high, and 4/5 are channel 1 low/high. A write to a count byte replaces that byte's increment in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| tick | input | 2 | Per-channel timer tick enable |
| ext_pin | input | 2 | Synchronized external count pins |
| gate_pin | input | 2 | Gate pins, active high |
| ack | input | 2 | Interrupt vector acknowledge per flag |
| ch0_count | output | 16 | Channel 0 {high, low} |
| ch1_count | output | 16 | Channel 1 {high, low} |
| ovf_flag | output | 2 | Overflow flags, bit n for channel n |
| ch1_ovf_pulse | output | 1 | One-cycle channel 1 overflow pulse |

## Verification
The bench steps each mode across its wrap point and compares against values it computes itself, one clock at a time:

- In 13-bit mode it checks that the upper low-byte bits survive the wrap. A design that carried through all eight low bits would report the wrong count and miss the flag.
- In auto-reload mode it runs many reloads. A design that reloaded one cycle late would show 0x00 instead of the high byte.
- In split mode it checks that each half-channel touches only its own flag, and that channel 1 neither sets flag 1 nor obeys its run bit. A design that mixed these up would move the wrong byte or raise a stray flag.
- It lets a hardware overflow and a software clear land in the same clock. A design with the wrong priority loses the event.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;
    localparam int TMR_BW     = 8;
    localparam int TMR_M13_LO = 5;
    localparam int TMR_AW     = 3;

    localparam logic [TMR_AW-1:0] A_CTRL = 3'd0;
    localparam logic [TMR_AW-1:0] A_MODE = 3'd1;
    localparam logic [TMR_AW-1:0] A_C0LO = 3'd2;
    localparam logic [TMR_AW-1:0] A_C0HI = 3'd3;
    localparam logic [TMR_AW-1:0] A_C1LO = 3'd4;
    localparam logic [TMR_AW-1:0] A_C1HI = 3'd5;

    typedef enum logic [1:0] {
        MD_13    = 2'b00,
        MD_16    = 2'b01,
        MD_RLD   = 2'b10,
        MD_SPLIT = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      ext_sel;
        logic      gate_en;
    } ch_cfg_t;

    typedef struct packed {
        logic [1:0]              run;
        logic [1:0]              flag;
        ch_cfg_t [1:0]           cfg;
        logic [1:0][TMR_BW-1:0]  lo;
        logic [1:0][TMR_BW-1:0]  hi;
        logic [1:0]              pin_prev;
        logic                    pulse;
    } tmr_state_t;
endpackage

// File: rtl/tmr_step.sv
module tmr_step
    import dual_tmr_pkg::*;
#(
    parameter int BW    = TMR_BW,
    parameter int LOW13 = TMR_M13_LO
) (
    input  tmr_mode_e       mode,
    input  logic            inc,
    input  logic [BW-1:0]   lo_i,
    input  logic [BW-1:0]   hi_i,
    output logic [BW-1:0]   lo_o,
    output logic [BW-1:0]   hi_o,
    output logic            ovf
);
    localparam int W13 = BW + LOW13;
    localparam int W16 = 2 * BW;

    logic [W13:0] s13;
    logic [W16:0] s16;
    logic [BW:0]  s8;

    always_comb begin
        lo_o = lo_i;
        hi_o = hi_i;
        ovf  = 1'b0;
        s13  = {1'b0, hi_i, lo_i[LOW13-1:0]} + (W13+1)'(1);
        s16  = {1'b0, hi_i, lo_i} + (W16+1)'(1);
        s8   = {1'b0, lo_i} + (BW+1)'(1);
        if (inc) begin
            case (mode)
                MD_13: begin
                    lo_o = {lo_i[BW-1:LOW13], s13[LOW13-1:0]};
                    hi_o = s13[W13-1:LOW13];
                    ovf  = s13[W13];
                end
                MD_16: begin
                    lo_o = s16[BW-1:0];
                    hi_o = s16[W16-1:BW];
                    ovf  = s16[W16];
                end
                MD_RLD: begin
                    ovf  = s8[BW];
                    lo_o = s8[BW] ? hi_i : s8[BW-1:0];
                end
                default: begin
                    // split / halted arrangement is resolved by the caller
                end
            endcase
        end
    end
endmodule

// File: rtl/tmr_flag_upd.sv
module tmr_flag_upd (
    input  logic hw_set,
    input  logic sw_we,
    input  logic sw_val,
    input  logic ack,
    input  logic q,
    output logic d
);
    always_comb begin
        if (hw_set)     d = 1'b1;
        else if (sw_we) d = sw_val;
        else if (ack)   d = 1'b0;
        else            d = q;
    end
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
    import dual_tmr_pkg::*;
#(
    parameter int BW    = TMR_BW,
    parameter int LOW13 = TMR_M13_LO,
    parameter int AW    = TMR_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [BW-1:0]   wr_data,
    input  logic [1:0]      tick,
    input  logic [1:0]      ext_pin,
    input  logic [1:0]      gate_pin,
    input  logic [1:0]      ack,
    output logic [2*BW-1:0] ch0_count,
    output logic [2*BW-1:0] ch1_count,
    output logic [1:0]      ovf_flag,
    output logic            ch1_ovf_pulse
);
    localparam logic [BW-1:0] BYTE_MAX = '1;

    tmr_state_t s_q, s_d;

    logic [1:0]         fall;
    logic [1:0]         qual;
    logic [1:0]         en;
    logic               split, c1_halt, hi0_en;
    logic               lo0_wrap, hi0_wrap;
    logic [1:0]         set_flag;
    logic [1:0]         flag_d;
    logic [1:0]         step_ovf;
    logic [1:0][BW-1:0] st_lo, st_hi;
    logic               wr_ctrl;

    assign split   = (s_q.cfg[0].mode == MD_SPLIT);
    assign c1_halt = (s_q.cfg[1].mode == MD_SPLIT);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    for (genvar g = 0; g < 2; g++) begin : g_ch
        assign fall[g] = s_q.pin_prev[g] & ~ext_pin[g];
        assign qual[g] = s_q.run[g] & (~s_q.cfg[g].gate_en | gate_pin[g])
                       & (s_q.cfg[g].ext_sel ? fall[g] : tick[g]);

        tmr_step #(.BW(BW), .LOW13(LOW13)) u_step (
            .mode (s_q.cfg[g].mode),
            .inc  (en[g]),
            .lo_i (s_q.lo[g]),
            .hi_i (s_q.hi[g]),
            .lo_o (st_lo[g]),
            .hi_o (st_hi[g]),
            .ovf  (step_ovf[g])
        );

        tmr_flag_upd u_flag (
            .hw_set (set_flag[g]),
            .sw_we  (wr_ctrl),
            .sw_val (wr_data[2+g]),
            .ack    (ack[g]),
            .q      (s_q.flag[g]),
            .d      (flag_d[g])
        );
    end

    always_comb begin
        en[0]       = qual[0];
        en[1]       = split ? (~c1_halt & tick[1]) : (qual[1] & ~c1_halt);
        hi0_en      = split & s_q.run[1] & tick[0];
        lo0_wrap    = split & en[0] & (s_q.lo[0] == BYTE_MAX);
        hi0_wrap    = hi0_en & (s_q.hi[0] == BYTE_MAX);
        set_flag[0] = split ? lo0_wrap : step_ovf[0];
        set_flag[1] = split ? hi0_wrap : step_ovf[1];
    end

    always_comb begin
        s_d          = s_q;
        s_d.pin_prev = ext_pin;
        s_d.pulse    = step_ovf[1];
        s_d.flag     = flag_d;
        s_d.lo[1]    = st_lo[1];
        s_d.hi[1]    = st_hi[1];
        if (split) begin
            s_d.lo[0] = s_q.lo[0] + BW'(en[0]);
            s_d.hi[0] = s_q.hi[0] + BW'(hi0_en);
        end else begin
            s_d.lo[0] = st_lo[0];
            s_d.hi[0] = st_hi[0];
        end
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: s_d.run = wr_data[1:0];
                A_MODE: begin
                    s_d.cfg[0].mode    = tmr_mode_e'(wr_data[1:0]);
                    s_d.cfg[0].ext_sel = wr_data[2];
                    s_d.cfg[0].gate_en = wr_data[3];
                    s_d.cfg[1].mode    = tmr_mode_e'(wr_data[5:4]);
                    s_d.cfg[1].ext_sel = wr_data[6];
                    s_d.cfg[1].gate_en = wr_data[7];
                end
                A_C0LO: s_d.lo[0] = wr_data;
                A_C0HI: s_d.hi[0] = wr_data;
                A_C1LO: s_d.lo[1] = wr_data;
                A_C1HI: s_d.hi[1] = wr_data;
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ch0_count     = {s_q.hi[0], s_q.lo[0]};
    assign ch1_count     = {s_q.hi[1], s_q.lo[1]};
    assign ovf_flag      = s_q.flag;
    assign ch1_ovf_pulse = s_q.pulse;

    AST_FLAG_HW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag[0] |=> ovf_flag[0]); // R11
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ack[0] && !set_flag[0] && !wr_ctrl |=> !ovf_flag[0]); // R11
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run[0] && !split && !(wr_en && (wr_addr == A_C0LO || wr_addr == A_C0HI))
        |=> $stable(ch0_count)); // R5
    AST_CH1_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        c1_halt && !split && !(wr_en && (wr_addr == A_C1LO || wr_addr == A_C1HI))
        |=> $stable(ch1_count)); // R10
    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_ovf_pulse |-> $past(en[1])); // R9
endmodule

// File: tb/test_dual_tmr.sv
module test_dual_tmr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  tick = '0, ext_pin = '0, gate_pin = '0, ack = '0;
    logic [15:0] ch0_count, ch1_count;
    logic [1:0]  ovf_flag;
    logic        ch1_ovf_pulse;
    int errs = 0, checks = 0;

    always #5 clk = ~clk;

    dual_tmr i_dual_tmr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick(tick), .ext_pin(ext_pin), .gate_pin(gate_pin), .ack(ack),
        .ch0_count(ch0_count), .ch1_count(ch1_count), .ovf_flag(ovf_flag),
        .ch1_ovf_pulse(ch1_ovf_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int ch, input int n);
        tick[ch] = 1'b1;
        repeat (n) @(negedge clk);
        tick[ch] = 1'b0;
    endtask

    initial begin
        #1ms;
        errs++; checks++;
        $display("FAIL watchdog act=hung exp=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] lo;
        logic       fl;
        int         np;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 counts", {ch0_count, ch1_count}, 32'h0);
        chk("R1 flags/pulse", {ovf_flag, ch1_ovf_pulse}, 3'b000);

        // R2 / R12: 16-bit sweep across the wrap
        wr(3'd1, 8'h01); wr(3'd2, 8'hF0); wr(3'd3, 8'hFF); wr(3'd0, 8'h01);
        tick[0] = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            chk("R2 count16", ch0_count, 16'(32'hFFF0 + i));
            chk("R2 flag16", ovf_flag[0], (i == 16));
        end
        tick[0] = 1'b0;
        ack[0] = 1'b1; @(negedge clk); ack[0] = 1'b0;
        chk("R11 ack clears", ovf_flag[0], 1'b0);

        // R3: 13-bit sweep
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'hFC); wr(3'd3, 8'hFF); wr(3'd0, 8'h01);
        tick[0] = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            logic [12:0] v;
            @(negedge clk);
            v = 13'(13'h1FFC + i);
            chk("R3 count13", ch0_count, {v[12:5], 3'b111, v[4:0]});
            chk("R3 flag13", ovf_flag[0], (i == 4));
        end
        tick[0] = 1'b0;

        // R4: auto-reload sweep
        wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr(3'd3, 8'hF0); wr(3'd2, 8'hFD); wr(3'd0, 8'h01);
        lo = 8'hFD; fl = 1'b0;
        tick[0] = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (lo == 8'hFF) begin lo = 8'hF0; fl = 1'b1; end
            else lo = lo + 8'd1;
            chk("R4 reload", ch0_count, {8'hF0, lo});
            chk("R4 flag", ovf_flag[0], fl);
        end
        tick[0] = 1'b0;

        // R5: gate and run
        wr(3'd0, 8'h00); wr(3'd1, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h01);
        ticks(0, 5);
        chk("R5 gate low holds", ch0_count, 16'd0);
        gate_pin[0] = 1'b1;
        ticks(0, 5);
        chk("R5 gate high counts", ch0_count, 16'd5);
        wr(3'd0, 8'h00);
        ticks(0, 5);
        chk("R5 run off holds", ch0_count, 16'd5);
        gate_pin[0] = 1'b0;

        // R6: external falling edges, tick ignored
        wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd0, 8'h01);
        tick[0] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            ext_pin[0] = 1'b1; @(negedge clk);
            ext_pin[0] = 1'b0; @(negedge clk);
        end
        tick[0] = 1'b0;
        chk("R6 edge count", ch0_count, 16'd6);

        // R7 / R8: split channel 0
        wr(3'd0, 8'h00); wr(3'd1, 8'h03); wr(3'd2, 8'hFE); wr(3'd3, 8'hFD); wr(3'd0, 8'h01);
        ticks(0, 2);
        chk("R7 low wraps alone", ch0_count, 16'hFD00);
        chk("R7 flag0 only", ovf_flag, 2'b01);
        wr(3'd0, 8'h02);
        ticks(0, 3);
        chk("R8 high counts", ch0_count, 16'h0000);
        chk("R8 sets flag1", ovf_flag, 2'b10);

        // R9: channel 1 during split ignores run bit, no flag, pulse kept
        wr(3'd0, 8'h00); wr(3'd1, 8'h13); wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
        tick[1] = 1'b1; np = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            np += ch1_ovf_pulse;
        end
        tick[1] = 1'b0;
        chk("R9 ch1 counts", ch1_count, 16'h0001);
        chk("R9 one pulse", np, 1);
        chk("R9 no flag1", ovf_flag[1], 1'b0);
        chk("R9 ch0 high untouched", ch0_count, 16'h0000);
        wr(3'd1, 8'h33);
        ticks(1, 4);
        chk("R9 mode11 halts", ch1_count, 16'h0001);

        // R10: channel 1 mode 11 outside split
        wr(3'd0, 8'h02); wr(3'd1, 8'h31);
        ticks(1, 4);
        chk("R10 halted", ch1_count, 16'h0001);
        chk("R10 no flag", ovf_flag[1], 1'b0);

        // R2: channel 1 normal overflow drives pulse and flag together
        wr(3'd1, 8'h11); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        ticks(1, 1);
        chk("R2 ch1 wrap", ch1_count, 16'h0000);
        chk("R2 pulse+flag", {ch1_ovf_pulse, ovf_flag[1]}, 2'b11);
        @(negedge clk);
        chk("R2 pulse one cycle", ch1_ovf_pulse, 1'b0);

        // R11: hardware set beats same-clock software clear
        wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd0, 8'h01);
        tick[0] = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h01;
        @(negedge clk);
        tick[0] = 1'b0; wr_en = 1'b0;
        chk("R11 hw over sw", ovf_flag[0], 1'b1);
        wr(3'd0, 8'h08);
        chk("R11 sw write", ovf_flag, 2'b10);
        ack[1] = 1'b1; @(negedge clk); ack[1] = 1'b0;
        chk("R11 ack1", ovf_flag, 2'b00);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule